// File: doc/BRIEF.md
# Programmable-Timing External Memory Bus Controller

This block turns single-word requests from an internal port into access cycles on an asynchronous external memory bus. The bus has six active-low chip selects, a 9-bit address, a 16-bit data path and active-low read and write strobes. The data path is split into an output word, an output-enable and an input word, and the chip's pad ring combines them into a bidirectional bus. Each chip select owns a 32-bit timing word. That word sets the strobe length for reads and for writes, an extra first-access latency for page or burst devices, the write hold and the bus turnaround gap. Requests to different chip selects can therefore reach devices of very different speeds.

A requester raises `req_valid` with the direction, chip select index, address and write data. It holds them until `req_ready` pulses for one cycle. On that pulse a read returns its word on `req_rdata`. The controller places the turnaround gaps on its own, so the requester never has to know which device it talked to before.

Top module: `ext_bus_ctrl`

## Requirements
- R1: During reset and after it, every chip select, `bus_oe_n` and `bus_we_n` are high, and `bus_dout_en` and `req_ready` are low.
- R2: An access asserts only the chip select named by `req_cs` (index i drives bit i of `bus_cs_n` low) and drives `req_addr` on `bus_addr`. No strobe and no data drive happen while all chip selects are high.
- R3: A read holds `bus_oe_n` low for rd_wait+1 cycles when it is not a first access. The word on `bus_din` in the last of those cycles is returned on `req_rdata`.
- R4: A write holds `bus_we_n` low for wr_wait+1 cycles while driving the write data. The chip select then stays low for wr_hold+1 more cycles with `bus_we_n` high and the same data still driven.
- R5: A first access adds rd_delta (reads) or wr_delta (writes) cycles to the strobe. An access is a first access when it follows reset, follows a cycle in which the controller sat idle with no request, targets a different chip select than the previous access, or differs in address bits [8:4] from the last access to its chip select.
- R6: After a read, an access to a different chip select, or a write to the same one, is preceded by max(1, recov) cycles with all chip selects high and no data drive. recov is the field of the read's chip select. No other order of accesses gets this gap.
- R7: `req_ready` is high for exactly one cycle per access, in the cycle after the chip select is released. A request is taken only while the controller is idle, so back-to-back requests see 2 + gap cycles with every chip select high between accesses.
- R8: A timing word written with `cfg_we` and index `cfg_cs` has rd_wait in bits [3:0], wr_wait in [7:4], rd_delta in [15:8], wr_delta in [23:16], wr_hold in [27:24] and recov in [31:28]. An access uses the word as it was when the request was taken, so a write in the same cycle applies from the next access on. Writes with an index of 6 or more change nothing, and all words reset to zero.
- R9: `bus_oe_n` and `bus_we_n` are never low together, and `bus_dout_en` is high only during write strobe and hold cycles, never while `bus_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_cs | input | 3 | Chip select index of the timing word |
| cfg_wdata | input | 32 | Timing word value |
| req_valid | input | 1 | Request present, held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 3 | Target chip select index |
| req_addr | input | 9 | Word address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Read data, valid with ready |
| bus_cs_n | output | 6 | Active-low chip selects |
| bus_addr | output | 9 | External address |
| bus_oe_n | output | 1 | Active-low read strobe |
| bus_we_n | output | 1 | Active-low write strobe |
| bus_dout | output | 16 | Data to the pad drivers |
| bus_dout_en | output | 1 | Pad driver enable |
| bus_din | input | 16 | Data from the pads |

## Verification
A wrong count or a wrong state shows up at the pins within the access it affects. A bad counter load or compare makes the strobe or hold length differ from the programmed field plus one. A stale page tag or idle flag adds or drops the first-access latency on the very next request. A lost read marker removes the turnaround gap, and the idle span between accesses then shrinks below 2 + max(1, recov). A capture made in the wrong cycle returns the filler word the bench model drives whenever no read strobe is active.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
   localparam int WAIT_W  = 4;
   localparam int DELTA_W = 8;
   localparam int HOLD_W  = 4;
   localparam int REC_W   = 4;

   // Field order fixes the bit positions of the timing word.
   typedef struct packed {
      logic [REC_W-1:0]   recov;
      logic [HOLD_W-1:0]  wr_hold;
      logic [DELTA_W-1:0] wr_delta;
      logic [DELTA_W-1:0] rd_delta;
      logic [WAIT_W-1:0]  wr_wait;
      logic [WAIT_W-1:0]  rd_wait;
   } timing_t;

   localparam int TIMING_W = $bits(timing_t);
   // Longest strobe: wait + 1 + delta.
   localparam int CNT_W    = DELTA_W + 2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RECOV,
      ST_ACT,
      ST_HOLD,
      ST_RESP
   } state_t;
endpackage

// File: rtl/ebc_cfg_bank.sv
module ebc_cfg_bank
   import ebc_pkg::*;
#(
   parameter int NUM_CS = 6,
   parameter int CS_W   = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [CS_W-1:0] wr_sel,
   input  timing_t         wr_data,
   input  logic [CS_W-1:0] rd_sel,
   output timing_t         rd_data
);
   timing_t word_q [NUM_CS];

   for (genvar i = 0; i < NUM_CS; i++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q[i] <= '0;
         else if (wr_en && (wr_sel == CS_W'(i)))
            word_q[i] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_CS; i++)
         if (rd_sel == CS_W'(i)) rd_data = word_q[i];
   end
endmodule

// File: rtl/ebc_page_tag.sv
module ebc_page_tag #(
   parameter int NUM_CS = 6,
   parameter int CS_W   = 3,
   parameter int TAG_W  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd,
   input  logic [CS_W-1:0]  sel,
   input  logic [TAG_W-1:0] tag,
   output logic             hit
);
   logic [TAG_W-1:0] tag_q [NUM_CS];
   logic [NUM_CS-1:0] vld_q;

   for (genvar i = 0; i < NUM_CS; i++) begin : g_tag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tag_q[i] <= '0;
            vld_q[i] <= 1'b0;
         end else if (upd && (sel == CS_W'(i))) begin
            tag_q[i] <= tag;
            vld_q[i] <= 1'b1;
         end
      end
   end

   always_comb begin
      hit = 1'b0;
      for (int i = 0; i < NUM_CS; i++)
         if (sel == CS_W'(i)) hit = vld_q[i] && (tag_q[i] == tag);
   end
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
   import ebc_pkg::*;
#(
   parameter int NUM_CS = 6,
   parameter int CS_W   = 3,
   parameter int ADDR_W = 9,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [CS_W-1:0]   req_cs,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  timing_t           tm,
   input  logic              page_hit,
   output logic              take,
   output logic              req_ready,
   output logic [DATA_W-1:0] req_rdata,
   output logic [NUM_CS-1:0] bus_cs_n,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_oe_n,
   output logic              bus_we_n,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_dout_en,
   input  logic [DATA_W-1:0] bus_din
);
   state_t             st;
   logic [CNT_W-1:0]   cnt;
   logic [CNT_W-1:0]   cur_len;
   logic               cur_w;
   logic [CS_W-1:0]    cur_cs;
   logic [ADDR_W-1:0]  cur_addr;
   logic [DATA_W-1:0]  cur_wdata;
   logic [HOLD_W-1:0]  cur_hold;
   logic [REC_W-1:0]   cur_rec;
   logic               last_rd;
   logic [CS_W-1:0]    last_cs;
   logic [REC_W-1:0]   last_rec;
   logic [DATA_W-1:0]  rdata_q;
   logic               idle_q;

   logic               first;
   logic               need_rec;
   logic [CNT_W-1:0]   acc_len;
   logic [CNT_W-1:0]   rec_len;
   logic               on_bus;

   assign take     = (st == ST_IDLE) && req_valid;
   assign first    = idle_q || (req_cs != last_cs) || !page_hit;
   assign need_rec = last_rd && ((req_cs != last_cs) || req_write);
   assign rec_len  = (last_rec == '0) ? CNT_W'(1) : CNT_W'(last_rec);

   always_comb begin
      if (req_write)
         acc_len = CNT_W'(tm.wr_wait) + CNT_W'(1) +
                   (first ? CNT_W'(tm.wr_delta) : CNT_W'(0));
      else
         acc_len = CNT_W'(tm.rd_wait) + CNT_W'(1) +
                   (first ? CNT_W'(tm.rd_delta) : CNT_W'(0));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cnt       <= '0;
         cur_len   <= '0;
         cur_w     <= 1'b0;
         cur_cs    <= '0;
         cur_addr  <= '0;
         cur_wdata <= '0;
         cur_hold  <= '0;
         cur_rec   <= '0;
         last_rd   <= 1'b0;
         last_cs   <= '0;
         last_rec  <= '0;
         rdata_q   <= '0;
         idle_q    <= 1'b1;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  cur_w     <= req_write;
                  cur_cs    <= req_cs;
                  cur_addr  <= req_addr;
                  cur_wdata <= req_wdata;
                  cur_hold  <= tm.wr_hold;
                  cur_rec   <= tm.recov;
                  cur_len   <= acc_len;
                  idle_q    <= 1'b0;
                  if (need_rec) begin
                     st  <= ST_RECOV;
                     cnt <= rec_len - CNT_W'(1);
                  end else begin
                     st  <= ST_ACT;
                     cnt <= acc_len - CNT_W'(1);
                  end
               end else begin
                  idle_q <= 1'b1;
               end
            end
            ST_RECOV: begin
               if (cnt == '0) begin
                  st  <= ST_ACT;
                  cnt <= cur_len - CNT_W'(1);
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            ST_ACT: begin
               if (cnt == '0) begin
                  if (cur_w) begin
                     st  <= ST_HOLD;
                     cnt <= CNT_W'(cur_hold);
                  end else begin
                     st      <= ST_RESP;
                     rdata_q <= bus_din;
                  end
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            ST_HOLD: begin
               if (cnt == '0) st <= ST_RESP;
               else           cnt <= cnt - CNT_W'(1);
            end
            ST_RESP: begin
               st       <= ST_IDLE;
               last_rd  <= !cur_w;
               last_cs  <= cur_cs;
               last_rec <= cur_rec;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign on_bus = (st == ST_ACT) || (st == ST_HOLD);

   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      assign bus_cs_n[i] = !(on_bus && (cur_cs == CS_W'(i)));
   end

   assign bus_addr    = cur_addr;
   assign bus_oe_n    = !((st == ST_ACT) && !cur_w);
   assign bus_we_n    = !((st == ST_ACT) && cur_w);
   assign bus_dout    = cur_wdata;
   assign bus_dout_en = on_bus && cur_w;
   assign req_ready   = (st == ST_RESP);
   assign req_rdata   = rdata_q;
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
   import ebc_pkg::*;
#(
   parameter int NUM_CS = 6,
   parameter int ADDR_W = 9,
   parameter int DATA_W = 16,
   parameter int PAGE_W = 4,
   localparam int CS_W  = $clog2(NUM_CS),
   localparam int TAG_W = ADDR_W - PAGE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [CS_W-1:0]     cfg_cs,
   input  logic [TIMING_W-1:0] cfg_wdata,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [CS_W-1:0]     req_cs,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   output logic                req_ready,
   output logic [DATA_W-1:0]   req_rdata,
   output logic [NUM_CS-1:0]   bus_cs_n,
   output logic [ADDR_W-1:0]   bus_addr,
   output logic                bus_oe_n,
   output logic                bus_we_n,
   output logic [DATA_W-1:0]   bus_dout,
   output logic                bus_dout_en,
   input  logic [DATA_W-1:0]   bus_din
);
   if (NUM_CS < 2 || NUM_CS > 8) begin : g_bad_cs
      $error("ext_bus_ctrl: NUM_CS must lie in 2..8");
   end
   if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
      $error("ext_bus_ctrl: PAGE_W must lie in 1..ADDR_W-1");
   end

   timing_t tm;
   logic    take;
   logic    page_hit;

   ebc_cfg_bank #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_sel  (cfg_cs),
      .wr_data (timing_t'(cfg_wdata)),
      .rd_sel  (req_cs),
      .rd_data (tm)
   );

   ebc_page_tag #(.NUM_CS(NUM_CS), .CS_W(CS_W), .TAG_W(TAG_W)) u_tag (
      .clk   (clk),
      .rst_n (rst_n),
      .upd   (take),
      .sel   (req_cs),
      .tag   (req_addr[ADDR_W-1:PAGE_W]),
      .hit   (page_hit)
   );

   ebc_seq #(.NUM_CS(NUM_CS), .CS_W(CS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_cs      (req_cs),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .tm          (tm),
      .page_hit    (page_hit),
      .take        (take),
      .req_ready   (req_ready),
      .req_rdata   (req_rdata),
      .bus_cs_n    (bus_cs_n),
      .bus_addr    (bus_addr),
      .bus_oe_n    (bus_oe_n),
      .bus_we_n    (bus_we_n),
      .bus_dout    (bus_dout),
      .bus_dout_en (bus_dout_en),
      .bus_din     (bus_din)
   );
endmodule

// File: rtl/ebc_chk.sv
module ebc_chk #(
   parameter int NUM_CS = 6,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CS-1:0] bus_cs_n,
   input logic              bus_oe_n,
   input logic              bus_we_n,
   input logic [DATA_W-1:0] bus_dout,
   input logic              bus_dout_en,
   input logic              req_ready
);
   assert_cs_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~bus_cs_n));

   assert_strobe_has_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_oe_n || !bus_we_n || bus_dout_en) |-> (~bus_cs_n != '0));

   assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_oe_n && !bus_we_n));

   assert_no_drive_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_dout_en |-> bus_oe_n);

   assert_hold_after_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_we_n) |-> (bus_dout_en && (~bus_cs_n != '0)));

   assert_wdata_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_dout_en && $past(bus_dout_en)) |-> $stable(bus_dout));

   assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> !req_ready);

   assert_ready_bus_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (bus_cs_n == '1));
endmodule

bind ext_bus_ctrl ebc_chk #(.NUM_CS(NUM_CS), .DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_cs_n    (bus_cs_n),
   .bus_oe_n    (bus_oe_n),
   .bus_we_n    (bus_we_n),
   .bus_dout    (bus_dout),
   .bus_dout_en (bus_dout_en),
   .req_ready   (req_ready)
);

// File: tb/tb_ext_bus_ctrl.sv
module tb_ext_bus_ctrl;
   localparam int NCS = 6;
   localparam int MEMN = NCS * 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_cs = '0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [2:0]  req_cs = '0;
   logic [8:0]  req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        req_ready;
   logic [15:0] req_rdata;
   logic [5:0]  bus_cs_n;
   logic [8:0]  bus_addr;
   logic        bus_oe_n, bus_we_n, bus_dout_en;
   logic [15:0] bus_dout, bus_din;

   always #2.5 clk = ~clk;

   ext_bus_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cs(cfg_cs), .cfg_wdata(cfg_wdata),
      .req_valid(req_valid), .req_write(req_write), .req_cs(req_cs), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_ready(req_ready), .req_rdata(req_rdata),
      .bus_cs_n(bus_cs_n), .bus_addr(bus_addr), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
      .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   function automatic logic [15:0] seed(input int cs, input int a);
      return 16'((cs * 16'h1111) ^ (a * 7 + 16'h0A50));
   endfunction

   function automatic int cs_of(input logic [5:0] n);
      int r = 0;
      for (int i = 0; i < NCS; i++) if (!n[i]) r = i;
      return r;
   endfunction

   // Device model on the bus side.
   logic [15:0] bus_mem [0:MEMN-1];
   logic [15:0] exp_mem [0:MEMN-1];
   initial begin
      for (int c = 0; c < NCS; c++)
         for (int a = 0; a < 512; a++) begin
            bus_mem[c*512+a] = seed(c, a);
            exp_mem[c*512+a] = seed(c, a);
         end
   end
   assign bus_din = !bus_oe_n ? bus_mem[cs_of(bus_cs_n)*512 + int'(bus_addr)] : 16'hDEAD;
   always @(posedge clk) if (!bus_we_n) bus_mem[cs_of(bus_cs_n)*512 + int'(bus_addr)] <= bus_dout;

   typedef struct {
      bit w; int cs; int addr; int data; int alen; int hlen; int gap; string ltag;
   } exp_t;
   exp_t exp_q[$];

   // Bench-side model of the timing words and access history.
   logic [31:0] cfgm [0:NCS-1];
   int  m_last_cs = 0;
   bit  m_last_rd = 0;
   int  m_last_rec = 0;
   bit  m_pv [0:NCS-1];
   int  m_tag [0:NCS-1];
   initial for (int i = 0; i < NCS; i++) begin cfgm[i] = '0; m_pv[i] = 0; m_tag[i] = 0; end

   task automatic cfg(input int cs, input logic [31:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_cs = 3'(cs); cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
      if (cs < NCS) cfgm[cs] = v;   // R8: indexes 6 and 7 ignored
   endtask

   task automatic do_req(input bit w, input int cs, input int a, input int d,
                         input bit pause, input bit mid, input logic [31:0] midv);
      exp_t e;
      bit first;
      int rec;
      logic [31:0] t;
      if (pause) begin
         req_valid = 1'b0;
         @(negedge clk);
         @(negedge clk);
      end
      t = cfgm[cs];
      first = pause || (cs != m_last_cs) || !m_pv[cs] || (m_tag[cs] != (a >> 4));
      e.w = w; e.cs = cs; e.addr = a;
      e.alen = (w ? int'(t[7:4]) : int'(t[3:0])) + 1 + (first ? (w ? int'(t[23:16]) : int'(t[15:8])) : 0);
      e.hlen = w ? int'(t[27:24]) + 1 : 0;
      e.ltag = first ? "R5" : (w ? "R4" : "R3");
      rec = 0;
      if (m_last_rd && (cs != m_last_cs || w)) rec = (m_last_rec == 0) ? 1 : m_last_rec;
      e.gap = pause ? -1 : 2 + rec;
      if (w) begin
         e.data = d;
         exp_mem[cs*512+a] = 16'(d);
      end else begin
         e.data = int'(exp_mem[cs*512+a]);
      end
      exp_q.push_back(e);
      m_pv[cs] = 1; m_tag[cs] = a >> 4;
      m_last_cs = cs; m_last_rd = !w;
      if (!w) m_last_rec = int'(t[31:28]);
      req_valid = 1'b1; req_write = w; req_cs = 3'(cs);
      req_addr = 9'(a); req_wdata = 16'(d);
      if (mid) begin
         cfg_we = 1'b1; cfg_cs = 3'(cs); cfg_wdata = midv;
         cfgm[cs] = midv;
      end
      do begin
         @(negedge clk);
         cfg_we = 1'b0;
      end while (!req_ready);
   endtask

   // Monitor: measures each bus access and compares with the queue head.
   bit  in_txn = 0;
   int  gap = 0, L = 0, H = 0, o_cs = 0, o_addr = 0, o_dout = 0;
   bit  o_w = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (!bus_oe_n && bus_dout_en) chk(0, "R9", "drive during read", 1, 0);
         if (bus_cs_n != 6'h3F) begin
            if (!in_txn) begin
               in_txn = 1; L = 0; H = 0;
               o_cs = cs_of(bus_cs_n); o_addr = int'(bus_addr);
               o_w = !bus_we_n; o_dout = int'(bus_dout);
               if (req_ready) chk(0, "R7", "ready during access", 1, 0);
            end
            if (!bus_oe_n || !bus_we_n) L++; else H++;
         end else if (in_txn) begin
            exp_t e;
            in_txn = 0;
            if (exp_q.size() == 0) begin
               chk(0, "R7", "unexpected access", 1, 0);
            end else begin
               e = exp_q.pop_front();
               chk(o_cs == e.cs, "R2", "chip select", o_cs, e.cs);
               chk(o_addr == e.addr, "R2", "address", o_addr, e.addr);
               chk(o_w == e.w, "R2", "direction", int'(o_w), int'(e.w));
               chk(L == e.alen, e.ltag, "strobe cycles", L, e.alen);
               chk(H == e.hlen, "R4", "hold cycles", H, e.hlen);
               if (e.gap >= 0) chk(gap == e.gap, "R6", "idle gap", gap, e.gap);
               chk(req_ready == 1'b1, "R7", "ready after release", int'(req_ready), 1);
               if (e.w) chk(o_dout == e.data, "R4", "write data", o_dout, e.data);
               else     chk(int'(req_rdata) == e.data, "R3", "read data", int'(req_rdata), e.data);
            end
            gap = 1;
         end else begin
            gap++;
            if (req_ready) chk(0, "R7", "stray ready", 1, 0);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      chk(0, "R7", "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: idle outputs under reset
      chk(bus_cs_n == 6'h3F, "R1", "cs_n in reset", int'(bus_cs_n), 63);
      chk(bus_oe_n && bus_we_n, "R1", "strobes in reset", int'({bus_oe_n, bus_we_n}), 3);
      chk(!bus_dout_en && !req_ready, "R1", "drive/ready in reset", int'({bus_dout_en, req_ready}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bus_cs_n == 6'h3F && bus_oe_n && bus_we_n && !bus_dout_en, "R1", "idle after reset",
          int'(bus_cs_n), 63);

      // R8: timing words; bits [3:0] rd_wait, [7:4] wr_wait, [15:8] rd_delta,
      // [23:16] wr_delta, [27:24] wr_hold, [31:28] recov
      cfg(0, 32'h3205_0312);
      cfg(1, 32'h0000_0000);
      cfg(3, 32'hF000_144F);
      cfg(5, 32'h1F02_01F0);
      cfg(7, 32'hFFFF_FFFF);   // R8: out-of-range index, must not touch cs 2 and 4

      do_req(0, 0, 'h010, 0, 1, 0, '0);      // R5 first after idle
      do_req(0, 0, 'h011, 0, 0, 0, '0);      // R3 same page
      do_req(0, 0, 'h025, 0, 0, 0, '0);      // R5 page change
      do_req(1, 0, 'h026, 'hA5A5, 0, 0, '0); // R6 read->write same cs
      do_req(0, 0, 'h026, 0, 0, 0, '0);      // R3 write->read, no gap
      do_req(0, 1, 'h005, 0, 0, 0, '0);      // R6 read->other cs
      do_req(1, 1, 'h007, 'h1234, 0, 0, '0); // R6 recov 0 still gives 1
      do_req(1, 5, 'h100, 'hBEEF, 0, 0, '0); // R4 long hold
      do_req(0, 3, 'h1FF, 0, 0, 0, '0);      // R5 long latency
      do_req(0, 3, 'h1F0, 0, 0, 0, '0);      // R3 same page
      do_req(0, 2, 'h040, 0, 0, 0, '0);      // R6 recov 15, R8 cs2 untouched
      do_req(1, 3, 'h1F3, 'h5A5A, 1, 1, 32'h0000_0000); // R8 change lands next access
      do_req(1, 3, 'h1F4, 'h0F0F, 0, 0, '0); // R8 new word in effect
      do_req(0, 3, 'h1F3, 0, 0, 0, '0);      // R3 read back
      do_req(0, 4, 'h1F3, 0, 0, 0, '0);      // R6 gap from new recov 0
      req_valid = 1'b0;
      repeat (10) @(negedge clk);
      chk(exp_q.size() == 0, "R7", "all accesses completed", exp_q.size(), 0);
      chk(bus_cs_n == 6'h3F && !req_ready, "R7", "idle at end", int'(bus_cs_n), 63);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule